// File: doc/BRIEF.md
# CPU Cluster PLL Retune Sequencer

This block retunes the PLL of either of two CPU clusters without glitching the cluster clock. A one-cycle request carries a cluster index and a multiplier. The multiplier is the target rate divided by the 24 MHz reference, so it is the PLL's N factor. The multiplier is range-checked first. A legal request then runs the sequence. The cluster's source-select bit in the shared CPU clock select register is cleared, which parks the cluster on the 24 MHz oscillator. The new N is merged into bits 15:8 of that cluster's PLL control register. The sequencer waits for the cluster's stable flag. Finally it sets the select bit again, which moves the cluster back onto its PLL.

Each cluster has its own sequencing engine, so both clusters can be retuned at the same time. The two engines share one select register. A round-robin arbiter does the read-modify-write on it, one bit per grant, so one engine never overwrites the other's bit. The analog PLL is replaced by a lock-delay model: writing N drops its stable flag, and the flag returns after a fixed number of cycles. A hold input keeps the flag low, which models a PLL that fails to lock. A lock timeout aborts a retune that never sees lock.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset the block is in this state: busy, done and error all 0; select register 32'h1001_1002, so both clusters are on their PLL; each PLL control register 32'h8001_2001; both stable flags 1.
- R2: The block rejects a multiplier below 0x11 or above 0xFF. The cluster's error bit pulses for one cycle, in the cycle after the request. Busy stays 0, and no register changes. The values 0x11 and 0xFF are both accepted.
- R3: For cluster c, the select bit sits at position 12+16·c, and 0 selects the oscillator. This bit is cleared before N is written. It stays 0 while the PLL relocks.
- R4: An accepted multiplier is written to bits 15:8 of the cluster's PLL control register. Every other bit of that register keeps its value, including the enable bit 31, the P bit 16 and the M field 1:0.
- R5: The sequencer waits for the cluster's stable flag (bit c of the stable output). Only then does it set the select bit again. After that it pulses done for one cycle.
- R6: A retune of one cluster leaves the other cluster's select bit unchanged. It also leaves every non-select bit of the shared register unchanged.
- R7: If lock is not seen within TIMEOUT cycles of waiting, error pulses and busy drops. The select bit stays 0, and it stays 0 after the PLL later locks.
- R8: Busy for a cluster rises when a legal request is accepted. It stays high until done or error. A request to a cluster that is busy is ignored.
- R9: Both clusters can be in a retune at once. The arbiter grants at most one select-register update per cycle. When the two return at the same time, both complete with both select bits set.
- R10: In the lock model, writing N clears the stable flag. The flag returns after LOCK_CYC+1 cycles unless hold is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | One-cycle retune request |
| req_cluster_i | input | 1 | Cluster index of the request |
| req_mult_i | input | 10 | Target rate divided by 24 MHz (N factor) |
| pll_hold_i | input | 2 | Lock-model hold per cluster, keeps stable low |
| busy_o | output | 2 | Retune in progress, per cluster |
| done_o | output | 2 | One-cycle completion pulse, per cluster |
| err_o | output | 2 | One-cycle reject or timeout pulse, per cluster |
| cpu_sel_o | output | 32 | Shared CPU clock select register |
| pll_ctrl_o | output | 64 | PLL control registers, cluster c at bits 32c+31:32c |
| stable_o | output | 2 | PLL stable status, bit c for cluster c |

## Verification
The assertions assume that a request is a single-cycle pulse carrying a defined cluster index. They also assume that the hold inputs are only raised to provoke lock failure, and never to break the ordering checks. The bench drives the request lines for exactly one cycle, away from the clock edge. It only raises hold around a request it expects to time out, or to line up two returns in the same cycle. Every retune is left to finish before a register value is compared.

// File: rtl/pll_retune_pkg.sv
package pll_retune_pkg;
  localparam int REG_W = 32;
  localparam int N_W   = 8;
  localparam int N_LSB = 8;
  localparam logic [REG_W-1:0] N_MASK = 32'h0000_FF00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PARK,
    ST_WRN,
    ST_WAIT,
    ST_UNPARK
  } seq_state_e;

  function automatic int sel_pos(int c);
    return 12 + 16 * c;
  endfunction

  function automatic logic [REG_W-1:0] sel_mask(int n);
    logic [REG_W-1:0] m;
    m = '0;
    for (int c = 0; c < n; c++) m[sel_pos(c)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pll_lock_model.sv
module pll_lock_model
  import pll_retune_pkg::*;
#(
  parameter int               LOCK_CYC = 20,
  parameter logic [REG_W-1:0] CTRL_RST = 32'h8001_2001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             n_wr_i,
  input  logic [N_W-1:0]   n_i,
  input  logic             hold_i,
  output logic [REG_W-1:0] ctrl_o,
  output logic             stable_o
);
  localparam int CNT_W = $clog2(LOCK_CYC + 1);

  logic [REG_W-1:0] ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             stable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= CTRL_RST;
      cnt_q    <= '0;
      stable_q <= 1'b1;
    end else if (n_wr_i) begin
      ctrl_q[N_LSB +: N_W] <= n_i;
      cnt_q    <= CNT_W'(LOCK_CYC);
      stable_q <= 1'b0;
    end else if (!stable_q) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      else if (!hold_i) stable_q <= 1'b1;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign stable_o = stable_q;

  // R4
  ctrl_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(ctrl_q & ~N_MASK));
  // R10
  stable_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stable_q) |-> $past(n_wr_i));
endmodule

// File: rtl/pll_sel_arb.sv
module pll_sel_arb
  import pll_retune_pkg::*;
#(
  parameter int               CLUSTERS = 2,
  parameter logic [REG_W-1:0] SEL_RST  = 32'h1001_1002
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CLUSTERS-1:0] req_i,
  input  logic [CLUSTERS-1:0] val_i,
  output logic [CLUSTERS-1:0] gnt_o,
  output logic [REG_W-1:0]    sel_o
);
  localparam int CL_W = (CLUSTERS > 1) ? $clog2(CLUSTERS) : 1;
  localparam logic [REG_W-1:0] SEL_MASK = sel_mask(CLUSTERS);

  logic [CL_W-1:0]  prio_q;
  logic [REG_W-1:0] sel_q;

  // round robin starting at prio_q
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < CLUSTERS; i++) begin
      int idx;
      idx = (int'(prio_q) + i) % CLUSTERS;
      if (req_i[idx] && !found) begin
        gnt_o[idx] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
      sel_q  <= SEL_RST;
    end else begin
      for (int c = 0; c < CLUSTERS; c++) begin
        if (gnt_o[c]) begin
          sel_q[sel_pos(c)] <= val_i[c];
          prio_q            <= CL_W'((c + 1) % CLUSTERS);
        end
      end
    end
  end

  assign sel_o = sel_q;

  // R9
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R6
  sel_other_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(sel_q & ~SEL_MASK));
endmodule

// File: rtl/pll_retune_engine.sv
module pll_retune_engine
  import pll_retune_pkg::*;
#(
  parameter int MULT_W  = 10,
  parameter int N_MIN   = 'h11,
  parameter int N_MAX   = 'hFF,
  parameter int TIMEOUT = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic              stable_i,
  input  logic              gnt_i,
  output logic              sel_req_o,
  output logic              sel_val_o,
  output logic              n_wr_o,
  output logic [N_W-1:0]    n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int TMR_W = $clog2(TIMEOUT + 1);

  seq_state_e       st_q;
  logic [N_W-1:0]   n_q;
  logic [TMR_W-1:0] tmr_q;
  logic             done_q, err_q;
  logic             in_range;

  assign in_range = (mult_i >= MULT_W'(N_MIN)) && (mult_i <= MULT_W'(N_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      n_q    <= '0;
      tmr_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            if (in_range) begin
              n_q  <= mult_i[N_W-1:0];
              st_q <= ST_PARK;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_PARK: if (gnt_i) st_q <= ST_WRN;
        ST_WRN: begin
          st_q  <= ST_WAIT;
          tmr_q <= '0;
        end
        ST_WAIT: begin
          if (stable_i) begin
            st_q <= ST_UNPARK;
          end else if (tmr_q == TMR_W'(TIMEOUT - 1)) begin
            st_q  <= ST_IDLE;
            err_q <= 1'b1;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_UNPARK: begin
          if (gnt_i) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sel_req_o = (st_q == ST_PARK) || (st_q == ST_UNPARK);
  assign sel_val_o = (st_q == ST_UNPARK);
  assign n_wr_o    = (st_q == ST_WRN);
  assign n_o       = n_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;

  // R2
  reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !in_range) |=> (err_o && !busy_o));
  // R8
  ignore_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(n_q));
  // R8
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R7
  tmr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_q < TMR_W'(TIMEOUT));
  // R5
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!err_o && !busy_o));
endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
  import pll_retune_pkg::*;
#(
  parameter int               CLUSTERS = 2,
  parameter int               MULT_W   = 10,
  parameter int               N_MIN    = 'h11,
  parameter int               N_MAX    = 'hFF,
  parameter int               TIMEOUT  = 64,
  parameter int               LOCK_CYC = 20,
  parameter logic [REG_W-1:0] SEL_RST  = 32'h1001_1002,
  parameter logic [REG_W-1:0] CTRL_RST = 32'h8001_2001,
  localparam int              CL_W     = (CLUSTERS > 1) ? $clog2(CLUSTERS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic [CL_W-1:0]           req_cluster_i,
  input  logic [MULT_W-1:0]         req_mult_i,
  input  logic [CLUSTERS-1:0]       pll_hold_i,
  output logic [CLUSTERS-1:0]       busy_o,
  output logic [CLUSTERS-1:0]       done_o,
  output logic [CLUSTERS-1:0]       err_o,
  output logic [REG_W-1:0]          cpu_sel_o,
  output logic [CLUSTERS*REG_W-1:0] pll_ctrl_o,
  output logic [CLUSTERS-1:0]       stable_o
);
  logic [CLUSTERS-1:0] sel_req, sel_val, gnt, n_wr;

  pll_sel_arb #(
    .CLUSTERS(CLUSTERS),
    .SEL_RST (SEL_RST)
  ) arb_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (sel_req),
    .val_i (sel_val),
    .gnt_o (gnt),
    .sel_o (cpu_sel_o)
  );

  for (genvar c = 0; c < CLUSTERS; c++) begin : g_cl
    logic           start;
    logic [N_W-1:0] n_val;

    assign start = req_valid_i && (req_cluster_i == CL_W'(c));

    pll_retune_engine #(
      .MULT_W (MULT_W),
      .N_MIN  (N_MIN),
      .N_MAX  (N_MAX),
      .TIMEOUT(TIMEOUT)
    ) eng_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start),
      .mult_i   (req_mult_i),
      .stable_i (stable_o[c]),
      .gnt_i    (gnt[c]),
      .sel_req_o(sel_req[c]),
      .sel_val_o(sel_val[c]),
      .n_wr_o   (n_wr[c]),
      .n_o      (n_val),
      .busy_o   (busy_o[c]),
      .done_o   (done_o[c]),
      .err_o    (err_o[c])
    );

    pll_lock_model #(
      .LOCK_CYC(LOCK_CYC),
      .CTRL_RST(CTRL_RST)
    ) pll_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .n_wr_i  (n_wr[c]),
      .n_i     (n_val),
      .hold_i  (pll_hold_i[c]),
      .ctrl_o  (pll_ctrl_o[c*REG_W +: REG_W]),
      .stable_o(stable_o[c])
    );

    // R3
    park_before_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      n_wr[c] |-> !cpu_sel_o[sel_pos(c)]);
    // R5
    lock_before_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cpu_sel_o[sel_pos(c)]) |-> stable_o[c]);
  end
endmodule

// File: tb/pll_retune_seq_tb_top.sv
module pll_retune_seq_tb_top;
  localparam logic [31:0] SEL_RST  = 32'h1001_1002;
  localparam logic [31:0] CTRL_RST = 32'h8001_2001;
  // {ok, cluster, mult[9:0]}
  localparam logic [11:0] VEC [8] = '{
    {1'b0, 1'b0, 10'h010}, {1'b1, 1'b0, 10'h011},
    {1'b1, 1'b1, 10'h0FF}, {1'b0, 1'b1, 10'h100},
    {1'b1, 1'b0, 10'h03A}, {1'b0, 1'b1, 10'h000},
    {1'b1, 1'b1, 10'h02C}, {1'b0, 1'b0, 10'h3FF}
  };

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req_valid = 1'b0, req_cluster = 1'b0;
  logic [9:0]  req_mult = '0;
  logic [1:0]  hold = '0;
  logic [1:0]  busy, done, err, stable;
  logic [31:0] cpu_sel;
  logic [63:0] pll_ctrl;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_sel;
  logic [31:0] exp_ctrl [2];

  always #5 clk = ~clk;

  pll_retune_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid),
    .req_cluster_i(req_cluster), .req_mult_i(req_mult), .pll_hold_i(hold),
    .busy_o(busy), .done_o(done), .err_o(err), .cpu_sel_o(cpu_sel),
    .pll_ctrl_o(pll_ctrl), .stable_o(stable)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic issue(int c, logic [9:0] m);
    @(negedge clk);
    req_valid = 1'b1; req_cluster = c[0]; req_mult = m;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_end(int c, output bit ok, output bit seen);
    ok = 0; seen = 0;
    for (int i = 0; i < 400; i++) begin
      if (done[c]) begin ok = 1; seen = 1; break; end
      if (err[c]) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] with_n(logic [31:0] r, logic [7:0] n);
    logic [31:0] t;
    t = r; t[15:8] = n;
    return t;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit ok, seen;
    exp_sel = SEL_RST; exp_ctrl[0] = CTRL_RST; exp_ctrl[1] = CTRL_RST;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", 64'(busy), 64'(0));
    check("R1 sel", 64'(cpu_sel), 64'(SEL_RST));
    check("R1 ctrl", pll_ctrl, {CTRL_RST, CTRL_RST});
    check("R1 stable", 64'(stable), 64'(2'b11));
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 done/err", 64'({done, err}), 64'(0));

    for (int v = 0; v < 8; v++) begin
      int c;
      c = int'(VEC[v][10]);
      issue(c, VEC[v][9:0]);
      if (VEC[v][11]) begin
        @(negedge clk); @(negedge clk);
        check("R3 parked", 64'(cpu_sel[12+16*c]), 64'(0));
        check("R10 stable low", 64'(stable[c]), 64'(0));
        check("R8 busy", 64'(busy[c]), 64'(1));
        wait_end(c, ok, seen);
        check("R5 done", 64'({seen, ok}), 64'(2'b11));
        check("R8 busy off", 64'(busy[c]), 64'(0));
        exp_ctrl[c] = with_n(exp_ctrl[c], VEC[v][7:0]);
      end else begin
        check("R2 err", 64'({err[c], busy[c]}), 64'(2'b10));
      end
      check("R4 ctrl", pll_ctrl, {exp_ctrl[1], exp_ctrl[0]});
      check("R6 sel", 64'(cpu_sel), 64'(exp_sel));
    end

    // R8 request to busy cluster ignored
    issue(1, 10'h040);
    issue(1, 10'h050);
    wait_end(1, ok, seen);
    check("R8 first done", 64'({seen, ok}), 64'(2'b11));
    exp_ctrl[1] = with_n(exp_ctrl[1], 8'h40);
    repeat (5) @(negedge clk);
    check("R8 no restart", 64'(busy), 64'(0));
    check("R8 ctrl", pll_ctrl, {exp_ctrl[1], exp_ctrl[0]});

    // R7 timeout
    hold = 2'b01;
    issue(0, 10'h055);
    wait_end(0, ok, seen);
    check("R7 err", 64'({seen, ok}), 64'(2'b10));
    check("R7 busy", 64'(busy[0]), 64'(0));
    exp_ctrl[0] = with_n(exp_ctrl[0], 8'h55);
    exp_sel[12] = 1'b0;
    check("R7 sel", 64'(cpu_sel), 64'(exp_sel));
    hold = 2'b00;
    repeat (30) @(negedge clk);
    check("R7 stays parked", 64'(cpu_sel), 64'(exp_sel));
    issue(0, 10'h056);
    wait_end(0, ok, seen);
    check("R7 recover", 64'({seen, ok}), 64'(2'b11));
    exp_ctrl[0] = with_n(exp_ctrl[0], 8'h56);
    exp_sel[12] = 1'b1;
    check("R7 sel back", 64'(cpu_sel), 64'(exp_sel));

    // R9 both clusters, simultaneous return
    hold = 2'b11;
    issue(0, 10'h030);
    issue(1, 10'h031);
    repeat (40) @(negedge clk);
    check("R9 both busy", 64'(busy), 64'(2'b11));
    check("R9 both parked", 64'(cpu_sel), 64'(SEL_RST & ~32'h1000_1000));
    hold = 2'b00;
    begin
      bit d0, d1;
      d0 = 0; d1 = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (done[0]) d0 = 1;
        if (done[1]) d1 = 1;
      end
      check("R9 both done", 64'({d1, d0}), 64'(2'b11));
    end
    exp_ctrl[0] = with_n(exp_ctrl[0], 8'h30);
    exp_ctrl[1] = with_n(exp_ctrl[1], 8'h31);
    check("R9 sel", 64'(cpu_sel), 64'(SEL_RST));
    check("R9 ctrl", pll_ctrl, {exp_ctrl[1], exp_ctrl[0]});
    finish_run();
  end
endmodule